// File: doc/BRIEF.md
# Debug Command Executor

This block runs on the target side of a debug link and handles commands whose bits have already been collected into whole bytes and words. The host sends an 8-bit opcode strobe. The block then reads or writes one of five 16-bit registers: program counter, D accumulator, X index, Y index and stack pointer. It can also step X forward by two and read or write the memory word at the new X, or hand control to the core so that it runs, runs one instruction, or runs with tagging enabled.

A register read returns its value in a holding register one cycle after the opcode, together with a one-cycle valid pulse. A write opcode parks the block until the host sends the 16-bit data word. Memory traffic uses a request/acknowledge port. The block keeps the request raised until the acknowledge arrives. If an access takes longer than one cycle, a freeze output stops the core clocks for the extra cycles. A run or step request stays raised until the core acknowledges. At that point the block records whether the core has returned to debug mode.

Top module: `dbg_cmd_exec`

## Requirements
- R1: Synchronous active-high reset clears D, X, Y and SP to 0, loads PC with the RESET_PC parameter, sets in_debug to 1, and leaves every request, freeze and pulse output low.
- R2: An opcode accepted in idle reads a register: 0x63 reads PC, 0x64 reads D, 0x65 reads X, 0x66 reads Y and 0x67 reads SP. The full 16-bit value is on rdata in the cycle after the opcode, with rdata_valid high for that one cycle.
- R3: Opcodes 0x43 to 0x47 write PC, D, X, Y and SP in that order. The target register changes only when the following wdata_valid word arrives, and no rdata_valid pulse is produced.
- R4: Opcode 0x62 adds 2 to X, modulo 2^16, and then reads memory at the new X. The memory word is returned on rdata with a one-cycle rdata_valid.
- R5: Opcode 0x42 waits for a data word, then adds 2 to X and writes that word to memory at the new X, with mem_we high.
- R6: mem_req and mem_addr stay steady until mem_ack. freeze is high for every cycle of an access after its first one. An access acknowledged in its first cycle raises no freeze.
- R7: Opcode 0x08 raises run_req and run_pending and clears in_debug. Both stay high until core_ack.
- R8: Opcode 0x10 raises step_req in place of run_req. When core_ack arrives, in_debug takes the value of core_halted. At most one of run_req, step_req and mem_req is high at any time.
- R9: Opcode 0x18 sets tag_en and raises run_req. Launching with 0x08 or 0x10 clears tag_en.
- R10: Any other opcode in idle raises cmd_err for one cycle, gives no rdata_valid, and changes no register.
- R11: An opcode that arrives while the block is waiting for a data word, a memory acknowledge or a core acknowledge has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Opcode strobe |
| op_code | input | 8 | Command opcode |
| wdata_valid | input | 1 | Data word strobe for write commands |
| wdata | input | 16 | Data word for write commands |
| rdata | output | 16 | Read result holding register |
| rdata_valid | output | 1 | One-cycle pulse marking a new read result |
| cmd_err | output | 1 | One-cycle pulse for an unrecognized opcode |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable (valid while mem_req) |
| mem_addr | output | 16 | Memory word address (current X) |
| mem_wdata | output | 16 | Memory write data |
| mem_ack | input | 1 | Memory access complete |
| mem_rdata | input | 16 | Memory read data |
| freeze | output | 1 | Core clock stall during multi-cycle accesses |
| core_ack | input | 1 | Core acknowledges a run or step request |
| core_halted | input | 1 | Core is back in debug mode at core_ack |
| run_req | output | 1 | Run request to the core |
| step_req | output | 1 | Single-instruction request to the core |
| tag_en | output | 1 | Tagging enabled |
| run_pending | output | 1 | Waiting for core acknowledge |
| in_debug | output | 1 | Core is in debug mode |

## Verification
The main table writes a different value into each register and reads all of them back. This shows whether the opcode-to-register mapping is wrong or two registers are swapped. Next-word reads and writes are mixed with explicit X writes, so the checks can tell a pre-increment from a post-increment and confirm that the written word is read back from the same address. Memory latencies of zero and three cycles separate a correct freeze count from freeze being raised on every access or never. The directed cases cover X wrapping from 0xFFFE, an unknown opcode, an opcode sent during a pending write, and the run, step and tag launches acknowledged with the core halted or still running.

// File: rtl/dbg_cmd_pkg.sv
package dbg_cmd_pkg;

    localparam int OPW      = 8;
    localparam int NUM_REGS = 5;

    typedef enum logic [2:0] {
        K_NONE, K_RD_REG, K_WR_REG, K_RD_NEXT, K_WR_NEXT, K_GO, K_STEP, K_TAGGO
    } cmd_kind_e;

    // order matches the low opcode bits minus three
    typedef enum logic [2:0] {
        SEL_PC, SEL_D, SEL_X, SEL_Y, SEL_SP
    } reg_sel_e;

    typedef struct packed {
        cmd_kind_e kind;
        reg_sel_e  sel;
    } cmd_dec_t;

    typedef enum logic [1:0] {
        S_IDLE, S_DATA, S_MEM, S_RUN
    } seq_state_e;

    localparam logic [OPW-1:0] OP_RD_GROUP = 8'h60;
    localparam logic [OPW-1:0] OP_WR_GROUP = 8'h40;
    localparam logic [OPW-1:0] OP_GO       = 8'h08;
    localparam logic [OPW-1:0] OP_STEP     = 8'h10;
    localparam logic [OPW-1:0] OP_TAGGO    = 8'h18;

    function automatic cmd_dec_t decode_op(input logic [OPW-1:0] op);
        cmd_dec_t   d;
        logic [2:0] low;
        logic       is_rd;
        logic       is_wr;
        d.kind = K_NONE;
        d.sel  = SEL_PC;
        low    = op[2:0];
        is_rd  = (op[OPW-1:3] == OP_RD_GROUP[OPW-1:3]);
        is_wr  = (op[OPW-1:3] == OP_WR_GROUP[OPW-1:3]);
        if ((is_rd || is_wr) && low >= 3'd2) begin
            if (low == 3'd2) begin
                d.kind = is_rd ? K_RD_NEXT : K_WR_NEXT;
            end else begin
                d.kind = is_rd ? K_RD_REG : K_WR_REG;
                d.sel  = reg_sel_e'(3'(low - 3'd3));
            end
        end else begin
            case (op)
                OP_GO:    d.kind = K_GO;
                OP_STEP:  d.kind = K_STEP;
                OP_TAGGO: d.kind = K_TAGGO;
                default:  d.kind = K_NONE;
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/dbg_cmd_decode.sv
module dbg_cmd_decode
    import dbg_cmd_pkg::*;
(
    input  logic [OPW-1:0] op_code,
    output cmd_dec_t       dec
);
    always_comb dec = decode_op(op_code);
endmodule

// File: rtl/dbg_regfile.sv
module dbg_regfile
    import dbg_cmd_pkg::*;
#(
    parameter int            DW       = 16,
    parameter logic [DW-1:0] RESET_PC = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  reg_sel_e      wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic          x_inc,
    input  reg_sel_e      rd_sel,
    output logic [DW-1:0] rd_data,
    output logic [DW-1:0] x_val
);
    localparam int XI = int'(SEL_X);
    localparam logic [DW-1:0] STEP2 = DW'(2);

    logic [DW-1:0] regs_q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam logic [DW-1:0] RV = (g == int'(SEL_PC)) ? RESET_PC : '0;
        logic [DW-1:0] val_q;
        always_ff @(posedge clk) begin
            if (rst)
                val_q <= RV;
            else if (wr_en && int'(wr_sel) == g)
                val_q <= wr_data;
            else if (g == XI && x_inc)
                val_q <= val_q + STEP2;
        end
        assign regs_q[g] = val_q;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (int'(rd_sel) == i) rd_data = regs_q[i];
    end

    assign x_val = regs_q[XI];

    p_x_step_r4: assert property (@(posedge clk) disable iff (rst)
        x_inc |=> x_val == $past(x_val) + STEP2);

endmodule

// File: rtl/dbg_cmd_seq.sv
module dbg_cmd_seq
    import dbg_cmd_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          op_valid,
    input  cmd_dec_t      dec,
    input  logic          wdata_valid,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] rf_rd_data,
    output reg_sel_e      rf_rd_sel,
    output logic          rf_wr_en,
    output reg_sel_e      rf_wr_sel,
    output logic [DW-1:0] rf_wr_data,
    output logic          x_inc,
    output logic [DW-1:0] rdata,
    output logic          rdata_valid,
    output logic          cmd_err,
    output logic          mem_req,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    output logic          freeze,
    input  logic          core_ack,
    input  logic          core_halted,
    output logic          run_req,
    output logic          step_req,
    output logic          tag_en,
    output logic          run_pending,
    output logic          in_debug
);
    seq_state_e    state_q;
    cmd_dec_t      pend_q;
    logic          first_q, step_q, we_q, rvalid_q, err_q, tag_q, dbg_q;
    logic [DW-1:0] wbuf_q, rdata_q;

    logic idle_op, data_in;
    assign idle_op = (state_q == S_IDLE) && op_valid;
    assign data_in = (state_q == S_DATA) && wdata_valid;

    assign rf_rd_sel  = dec.sel;
    assign rf_wr_en   = data_in && pend_q.kind == K_WR_REG;
    assign rf_wr_sel  = pend_q.sel;
    assign rf_wr_data = wdata;
    assign x_inc      = (idle_op && dec.kind == K_RD_NEXT)
                     || (data_in && pend_q.kind == K_WR_NEXT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= S_IDLE;
            pend_q   <= '{kind: K_NONE, sel: SEL_PC};
            first_q  <= 1'b0;
            step_q   <= 1'b0;
            we_q     <= 1'b0;
            rvalid_q <= 1'b0;
            err_q    <= 1'b0;
            tag_q    <= 1'b0;
            dbg_q    <= 1'b1;
            wbuf_q   <= '0;
            rdata_q  <= '0;
        end else begin
            rvalid_q <= 1'b0;
            err_q    <= 1'b0;
            case (state_q)
                S_IDLE: if (op_valid) begin
                    case (dec.kind)
                        K_RD_REG: begin
                            rdata_q  <= rf_rd_data;
                            rvalid_q <= 1'b1;
                        end
                        K_RD_NEXT: begin
                            state_q <= S_MEM;
                            we_q    <= 1'b0;
                            first_q <= 1'b1;
                        end
                        K_WR_REG, K_WR_NEXT: begin
                            pend_q  <= dec;
                            state_q <= S_DATA;
                        end
                        K_GO, K_TAGGO: begin
                            state_q <= S_RUN;
                            step_q  <= 1'b0;
                            tag_q   <= (dec.kind == K_TAGGO);
                            dbg_q   <= 1'b0;
                        end
                        K_STEP: begin
                            state_q <= S_RUN;
                            step_q  <= 1'b1;
                            tag_q   <= 1'b0;
                            dbg_q   <= 1'b0;
                        end
                        default: err_q <= 1'b1;
                    endcase
                end
                S_DATA: if (wdata_valid) begin
                    if (pend_q.kind == K_WR_NEXT) begin
                        state_q <= S_MEM;
                        we_q    <= 1'b1;
                        wbuf_q  <= wdata;
                        first_q <= 1'b1;
                    end else begin
                        state_q <= S_IDLE;
                    end
                end
                S_MEM: begin
                    first_q <= 1'b0;
                    if (mem_ack) begin
                        if (!we_q) begin
                            rdata_q  <= mem_rdata;
                            rvalid_q <= 1'b1;
                        end
                        state_q <= S_IDLE;
                    end
                end
                S_RUN: if (core_ack) begin
                    dbg_q   <= core_halted;
                    state_q <= S_IDLE;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign rdata       = rdata_q;
    assign rdata_valid = rvalid_q;
    assign cmd_err     = err_q;
    assign mem_req     = (state_q == S_MEM);
    assign mem_we      = we_q;
    assign mem_wdata   = wbuf_q;
    assign freeze      = (state_q == S_MEM) && !first_q;
    assign run_req     = (state_q == S_RUN) && !step_q;
    assign step_req    = (state_q == S_RUN) && step_q;
    assign run_pending = (state_q == S_RUN);
    assign tag_en      = tag_q;
    assign in_debug    = dbg_q;

    p_freeze_req_r6: assert property (@(posedge clk) disable iff (rst)
        freeze |-> mem_req);
    p_req_hold_r6: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_we));
    p_run_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (run_req || step_req) && !core_ack |=> (run_req || step_req) && $stable(step_req));
    p_excl_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({run_req, step_req, mem_req}));
    p_err_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        cmd_err |-> !rdata_valid && state_q == S_IDLE);
    p_ignore_r11: assert property (@(posedge clk) disable iff (rst)
        state_q == S_DATA && !wdata_valid |=> state_q == S_DATA);

endmodule

// File: rtl/dbg_cmd_exec.sv
module dbg_cmd_exec
    import dbg_cmd_pkg::*;
#(
    parameter int            DW       = 16,
    parameter logic [DW-1:0] RESET_PC = 16'hF000
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           op_valid,
    input  logic [OPW-1:0] op_code,
    input  logic           wdata_valid,
    input  logic [DW-1:0]  wdata,
    output logic [DW-1:0]  rdata,
    output logic           rdata_valid,
    output logic           cmd_err,
    output logic           mem_req,
    output logic           mem_we,
    output logic [DW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    input  logic           mem_ack,
    input  logic [DW-1:0]  mem_rdata,
    output logic           freeze,
    input  logic           core_ack,
    input  logic           core_halted,
    output logic           run_req,
    output logic           step_req,
    output logic           tag_en,
    output logic           run_pending,
    output logic           in_debug
);
    cmd_dec_t      dec;
    reg_sel_e      rd_sel, wr_sel;
    logic          wr_en, x_inc;
    logic [DW-1:0] wr_data, rd_data, x_val;

    dbg_cmd_decode u_dec (
        .op_code (op_code),
        .dec     (dec)
    );

    dbg_regfile #(.DW(DW), .RESET_PC(RESET_PC)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .x_inc   (x_inc),
        .rd_sel  (rd_sel),
        .rd_data (rd_data),
        .x_val   (x_val)
    );

    dbg_cmd_seq #(.DW(DW)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .op_valid    (op_valid),
        .dec         (dec),
        .wdata_valid (wdata_valid),
        .wdata       (wdata),
        .rf_rd_data  (rd_data),
        .rf_rd_sel   (rd_sel),
        .rf_wr_en    (wr_en),
        .rf_wr_sel   (wr_sel),
        .rf_wr_data  (wr_data),
        .x_inc       (x_inc),
        .rdata       (rdata),
        .rdata_valid (rdata_valid),
        .cmd_err     (cmd_err),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_wdata   (mem_wdata),
        .mem_ack     (mem_ack),
        .mem_rdata   (mem_rdata),
        .freeze      (freeze),
        .core_ack    (core_ack),
        .core_halted (core_halted),
        .run_req     (run_req),
        .step_req    (step_req),
        .tag_en      (tag_en),
        .run_pending (run_pending),
        .in_debug    (in_debug)
    );

    assign mem_addr = x_val;

    p_addr_hold_r6: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> $stable(mem_addr));

endmodule

// File: tb/sim_dbg_cmd_exec.sv
module sim_dbg_cmd_exec;
    localparam logic [15:0] RPC = 16'hC100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0, wdata_valid = 1'b0;
    logic [7:0]  op_code = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata, mem_addr, mem_wdata;
    logic        rdata_valid, cmd_err, mem_req, mem_we, freeze;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        core_ack = 1'b0, core_halted = 1'b0;
    logic        run_req, step_req, tag_en, run_pending, in_debug;

    int checks = 0;
    int errors = 0;
    int lat = 1;
    int cnt = 0;
    logic [15:0] mdl [32];

    always #4 clk = ~clk;

    dbg_cmd_exec #(.DW(16), .RESET_PC(RPC)) u0 (
        .clk, .rst, .op_valid, .op_code, .wdata_valid, .wdata, .rdata, .rdata_valid,
        .cmd_err, .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_ack, .mem_rdata,
        .freeze, .core_ack, .core_halted, .run_req, .step_req, .tag_en,
        .run_pending, .in_debug
    );

    // memory responder: acknowledges after lat extra cycles
    always @(negedge clk) begin
        if (mem_req) begin
            if (cnt == lat) begin
                mem_ack <= 1'b1;
                if (mem_we) mdl[mem_addr[5:1]] <= mem_wdata;
                else        mem_rdata <= mdl[mem_addr[5:1]];
            end else begin
                mem_ack <= 1'b0;
                cnt     <= cnt + 1;
            end
        end else begin
            mem_ack <= 1'b0;
            cnt     <= 0;
        end
    end

    function automatic logic [15:0] fill(input int i);
        return 16'h3C00 + 16'(i) * 16'h0101;
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic send_op(input logic [7:0] op);
        @(negedge clk);
        op_valid = 1'b1;
        op_code  = op;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic send_data(input logic [15:0] d);
        @(negedge clk);
        wdata_valid = 1'b1;
        wdata       = d;
        @(negedge clk);
        wdata_valid = 1'b0;
    endtask

    task automatic wait_rd(output int nfz, output logic [15:0] d, output bit ok);
        nfz = 0; ok = 0; d = '0;
        for (int k = 0; k < 60; k++) begin
            if (rdata_valid) begin
                d = rdata; ok = 1; break;
            end
            if (freeze) nfz++;
            @(negedge clk);
        end
    endtask

    task automatic wait_mem_idle();
        for (int k = 0; k < 60 && mem_req; k++) @(negedge clk);
    endtask

    task automatic ack_core(input logic halted);
        @(negedge clk);
        core_halted = halted;
        core_ack    = 1'b1;
        @(negedge clk);
        core_ack    = 1'b0;
    endtask

    // {is_read, opcode, data, expected}
    localparam logic [40:0] VEC [16] = '{
        {1'b0, 8'h43, 16'h1234, 16'h0000},
        {1'b1, 8'h63, 16'h0000, 16'h1234},
        {1'b0, 8'h44, 16'hA55A, 16'h0000},
        {1'b0, 8'h46, 16'h0F0F, 16'h0000},
        {1'b0, 8'h47, 16'h7FF0, 16'h0000},
        {1'b0, 8'h45, 16'h0010, 16'h0000},
        {1'b1, 8'h64, 16'h0000, 16'hA55A},
        {1'b1, 8'h66, 16'h0000, 16'h0F0F},
        {1'b1, 8'h67, 16'h0000, 16'h7FF0},
        {1'b1, 8'h65, 16'h0000, 16'h0010},
        {1'b1, 8'h62, 16'h0000, 16'h4509},
        {1'b1, 8'h65, 16'h0000, 16'h0012},
        {1'b0, 8'h42, 16'hBEEF, 16'h0000},
        {1'b0, 8'h45, 16'h0012, 16'h0000},
        {1'b1, 8'h62, 16'h0000, 16'hBEEF},
        {1'b1, 8'h65, 16'h0000, 16'h0014}
    };

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int          nfz;
        logic [15:0] got;
        bit          ok;
        for (int i = 0; i < 32; i++) mdl[i] = fill(i);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 in_debug", 16'(in_debug), 16'h1);
        chk("R1 quiet", 16'({run_req, step_req, mem_req, freeze, rdata_valid, cmd_err, tag_en}), 16'h0);
        send_op(8'h63); chk("R1 pc", rdata, RPC);
        send_op(8'h65); chk("R1 x", rdata, 16'h0000);
        send_op(8'h64); chk("R1 d", rdata, 16'h0000);
        send_op(8'h67); chk("R1 sp", rdata, 16'h0000);

        // table walk: R2 reads, R3 writes, R4 read-next, R5 write-next
        for (int i = 0; i < 16; i++) begin
            logic        rd;
            logic [7:0]  op;
            logic [15:0] dat, ex;
            string       tag;
            rd  = VEC[i][40];
            op  = VEC[i][39:32];
            dat = VEC[i][31:16];
            ex  = VEC[i][15:0];
            tag = (op == 8'h62) ? "R4" : (op == 8'h42) ? "R5" : rd ? "R2" : "R3";
            send_op(op);
            if (rd) begin
                wait_rd(nfz, got, ok);
                chk(tag, ok ? got : 16'hxxxx, ex);
            end else begin
                chk({tag, " no valid"}, 16'(rdata_valid), 16'h0);
                send_data(dat);
                if (op == 8'h42) begin
                    chk("R5 mem_we", 16'(mem_we), 16'h1);
                    wait_mem_idle();
                end
            end
        end

        // R4 wrap of X
        send_op(8'h45); send_data(16'hFFFE);
        send_op(8'h62); wait_rd(nfz, got, ok);
        chk("R4 wrap data", got, fill(0));
        send_op(8'h65); chk("R4 wrap x", rdata, 16'h0000);

        // R6 freeze: single-cycle and three extra cycles
        lat = 0;
        send_op(8'h62); wait_rd(nfz, got, ok);
        chk("R6 no freeze", 16'(nfz), 16'h0);
        lat = 3;
        send_op(8'h62); wait_rd(nfz, got, ok);
        chk("R6 freeze cycles", 16'(nfz), 16'h3);
        chk("R6 data", got, fill(2));
        lat = 1;

        // R10 unknown opcode
        @(negedge clk); op_valid = 1'b1; op_code = 8'h55;
        @(negedge clk); op_valid = 1'b0;
        chk("R10 err", 16'(cmd_err), 16'h1);
        chk("R10 no valid", 16'(rdata_valid), 16'h0);
        @(negedge clk);
        chk("R10 pulse", 16'(cmd_err), 16'h0);
        send_op(8'h63); chk("R10 pc kept", rdata, 16'h1234);

        // R11 opcode during pending write
        send_op(8'h44);
        send_op(8'h63);
        chk("R11 ignored", 16'(rdata_valid), 16'h0);
        send_data(16'h1111);
        send_op(8'h64); chk("R11 d", rdata, 16'h1111);

        // R7 go
        send_op(8'h08);
        chk("R7 run", 16'({run_req, step_req, run_pending, in_debug}), 16'b1010);
        repeat (3) @(negedge clk);
        chk("R7 held", 16'(run_req), 16'h1);
        send_op(8'h63);
        chk("R11 run ignored", 16'(rdata_valid), 16'h0);
        ack_core(1'b0);
        chk("R7 done", 16'({run_req, run_pending, in_debug}), 16'b000);

        // R8 step
        send_op(8'h10);
        chk("R8 step", 16'({run_req, step_req}), 16'b01);
        ack_core(1'b1);
        chk("R8 back", 16'({step_req, in_debug}), 16'b01);

        // R9 tag-go
        send_op(8'h18);
        chk("R9 tag", 16'({tag_en, run_req}), 16'b11);
        ack_core(1'b1);
        chk("R9 kept", 16'({tag_en, in_debug}), 16'b11);
        send_op(8'h08);
        chk("R9 cleared", 16'(tag_en), 16'h0);
        ack_core(1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule